// File: doc/BRIEF.md
# Double-Buffered SPI Controller

This block is an 8-bit SPI port that works either as the clock-driving side or as the selected side of a link. The `is_master` input picks the role. A one-byte transmit holding register sits in front of the shift register, and a one-byte receive holding register sits behind it. Software can therefore queue the next byte while the current one is shifting, and can collect a finished byte while the next one arrives.

Software reaches the block over a plain 16-bit register bus with three word addresses:

- Status at 0x0. Bit 0 is transmit-holding-empty, bit 1 is receive-holding-full, bit 2 is the busy/selected flag, and every other bit is 0.
- Transmit data at 0x2. This register is write-only and reads as 0.
- Receive data at 0x4.

Bus reads are registered, so `bus_rdata` carries the value one clock after the `bus_rd` edge.

In the master role the block starts a byte on its own whenever the holding register has data and the shifter is idle. It shifts MSB first with the clock idle low, samples on the rising edge and changes data on the falling edge. In the slave role the external clock, select and data are brought into the system clock domain through two-flop synchronizers before any edge is detected.

Top module: `spi_dbuf_ctrl`

## Requirements
- R1: After reset the status register reads 0x0001 (transmit-holding-empty = 1, receive-holding-full = 0, busy = 0) and the receive data register reads 0x0000.
- R2: Status bits 15..3 always read 0. Data registers return the byte in bits 7..0 and 0 in bits 15..8. A read of the transmit address returns 0.
- R3: A write to address 0x2 clears transmit-holding-empty. The flag returns to 1 in the cycle the held byte is copied into the shift register, which is the start of that byte's transmission.
- R4: In master mode, status bit 2 becomes 1 when a byte is loaded into the shifter and stays 1 until the eighth SCLK falling edge, then returns to 0. `ss_n_out` is low exactly while busy. `sck_out` idles low and pulses 8 times per byte.
- R5: In master mode `sdo` presents the byte MSB first, stable at every `sck_out` rising edge. `sdi` is sampled on the rising edge and the received byte is assembled MSB first.
- R6: In master mode each `sck_out` half period lasts HALF_DIV system clocks, so one byte takes 16·HALF_DIV clocks.
- R7: Receive-holding-full becomes 1 when a complete byte is copied out of the shifter, and clears when address 0x4 is read. That read returns the byte.
- R8: If a byte completes while receive-holding-full is still 1, the receive register is overwritten by the newer byte and an internal sticky overrun flag is set.
- R9: A byte written while the previous one is still shifting is held with transmit-holding-empty = 0. It starts automatically after the current byte and is sent without being lost.
- R10: In slave mode, status bit 2 equals the inverted synchronized select input: 1 while `sel_n_in` is low and 0 while it is high.
- R11: In slave mode the held transmit byte is loaded when select falls and is shifted out on `sdo` MSB first, changing after each external falling edge. `sdi` bits sampled on external rising edges form the received byte.
- R12: In slave mode, raising `sel_n_in` in the middle of a byte discards the partial byte and resets the bit count. Receive-holding-full stays 0, and the next selection receives a correctly aligned byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = drive the SPI clock, 0 = be driven |
| bus_addr | input | 3 | Register byte address (0x0, 0x2, 0x4) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sck_out | output | 1 | SPI clock driven in master mode |
| ss_n_out | output | 1 | Active-low select driven in master mode |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sck_in | input | 1 | External SPI clock in slave mode |
| sel_n_in | input | 1 | External active-low select in slave mode |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
The assertions take the following for granted:

- `is_master` changes only while no byte is in flight.
- In slave mode, `sck_in` holds each level for well over three system clocks.
- `sel_n_in` moves only while `sck_in` is low.
- Software does not write the transmit register while it is full.

The directed bench respects all of this. It switches roles only between scenarios and toggles the external clock every eight system clocks. It moves select only with the clock low, and it waits for transmit-holding-empty before queuing a second byte.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] A_STATUS = 3'h0;
  localparam logic [REG_AW-1:0] A_TXDATA = 3'h2;
  localparam logic [REG_AW-1:0] A_RXDATA = 3'h4;

  localparam int SB_TXE  = 0;
  localparam int SB_RXF  = 1;
  localparam int SB_BUSY = 2;
endpackage

// File: rtl/spi_sync_2ff.sv
module spi_sync_2ff #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (tick)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int CHAR_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic              tx_avail,
  input  logic [CHAR_W-1:0] tx_byte,
  output logic              tx_take,
  output logic              rx_done,
  output logic [CHAR_W-1:0] rx_byte,
  output logic              m_busy,
  output logic              sel_active,
  output logic              sck_out,
  output logic              ss_n_out,
  output logic              sdo,
  input  logic              sck_in,
  input  logic              sel_n_in,
  input  logic              sdi
);
  localparam int BC_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(CHAR_W - 1);

  logic [CHAR_W-1:0] shreg;
  logic              smp;
  logic [BC_W-1:0]   bitcnt;
  logic              sclk_q;
  logic              tick;
  logic              sck_s, sel_s, sdi_s;
  logic              sck_d, sel_d;
  logic              sck_rise, sck_fall, sel_fall;
  logic              m_load, s_load_evt;

  spi_sync_2ff #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_in, sel_n_in, sdi}),
    .q   ({sck_s, sel_s, sdi_s})
  );

  spi_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (is_master && m_busy),
    .tick (tick)
  );

  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;
  assign sel_fall = !sel_s && sel_d;

  assign m_load     = is_master && !m_busy && tx_avail;
  assign s_load_evt = !is_master && !sel_s &&
                      (sel_fall || (sck_fall && bitcnt == BC_LAST));
  assign tx_take    = m_load || (s_load_evt && tx_avail);

  assign rx_byte = {shreg[CHAR_W-2:0], smp};
  assign rx_done = is_master ? (m_busy && tick && sclk_q && bitcnt == BC_LAST)
                             : (!sel_s && !sel_fall && sck_fall && bitcnt == BC_LAST);

  assign sdo        = shreg[CHAR_W-1];
  assign sck_out    = sclk_q;
  assign ss_n_out   = !m_busy;
  assign sel_active = !sel_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      sel_d <= 1'b1;
    end else begin
      sck_d <= sck_s;
      sel_d <= sel_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      smp    <= 1'b0;
      bitcnt <= '0;
      sclk_q <= 1'b0;
      m_busy <= 1'b0;
    end else if (is_master) begin
      if (!m_busy) begin
        sclk_q <= 1'b0;
        if (tx_avail) begin
          shreg  <= tx_byte;
          bitcnt <= '0;
          m_busy <= 1'b1;
        end
      end else if (tick) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          smp    <= sdi;
        end else begin
          sclk_q <= 1'b0;
          shreg  <= {shreg[CHAR_W-2:0], smp};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == BC_LAST) m_busy <= 1'b0;
        end
      end
    end else begin
      m_busy <= 1'b0;
      sclk_q <= 1'b0;
      if (sel_s) begin
        bitcnt <= '0;
      end else if (sel_fall) begin
        shreg  <= tx_avail ? tx_byte : '0;
        bitcnt <= '0;
      end else if (sck_rise) begin
        smp <= sdi_s;
      end else if (sck_fall) begin
        if (bitcnt == BC_LAST) begin
          shreg  <= tx_avail ? tx_byte : '0;
          bitcnt <= '0;
        end else begin
          shreg  <= {shreg[CHAR_W-2:0], smp};
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (is_master && !m_busy) |-> !sclk_q);

  p_start_low_r4: assert property (@(posedge clk) disable iff (rst)
    (is_master && $rose(m_busy)) |-> !sclk_q);

  p_abort_r12: assert property (@(posedge clk) disable iff (rst)
    (!is_master && sel_s) |=> (bitcnt == '0));

  p_no_done_unsel_r12: assert property (@(posedge clk) disable iff (rst)
    (!is_master && sel_s) |-> !rx_done);
endmodule

// File: rtl/spi_dbuf_ctrl.sv
module spi_dbuf_ctrl
  import spi_dbuf_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int CHAR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_DW-1:0] bus_wdata,
  output logic [REG_DW-1:0] bus_rdata,
  output logic              sck_out,
  output logic              ss_n_out,
  output logic              sdo,
  input  logic              sck_in,
  input  logic              sel_n_in,
  input  logic              sdi
);
  localparam int PAD_W = REG_DW - CHAR_W;

  logic [CHAR_W-1:0] tx_buf, rx_buf, rx_byte;
  logic              tx_empty, rx_full, ovr;
  logic              tx_take, rx_done, m_busy, sel_active;
  logic              wr_tx, rd_rx, busy_bit;

  assign wr_tx    = bus_wr && (bus_addr == A_TXDATA);
  assign rd_rx    = bus_rd && (bus_addr == A_RXDATA);
  assign busy_bit = is_master ? m_busy : sel_active;

  spi_shift_core #(.CHAR_W(CHAR_W), .HALF_DIV(HALF_DIV)) u_core (
    .clk        (clk),
    .rst        (rst),
    .is_master  (is_master),
    .tx_avail   (!tx_empty),
    .tx_byte    (tx_buf),
    .tx_take    (tx_take),
    .rx_done    (rx_done),
    .rx_byte    (rx_byte),
    .m_busy     (m_busy),
    .sel_active (sel_active),
    .sck_out    (sck_out),
    .ss_n_out   (ss_n_out),
    .sdo        (sdo),
    .sck_in     (sck_in),
    .sel_n_in   (sel_n_in),
    .sdi        (sdi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf   <= '0;
      tx_empty <= 1'b1;
    end else begin
      if (wr_tx) tx_buf <= bus_wdata[CHAR_W-1:0];
      if (wr_tx)        tx_empty <= 1'b0;
      else if (tx_take) tx_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (rx_done) begin
        rx_buf  <= rx_byte;
        rx_full <= 1'b1;
        if (rx_full && !rd_rx) ovr <= 1'b1;
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        A_STATUS: begin
          bus_rdata          <= '0;
          bus_rdata[SB_TXE]  <= tx_empty;
          bus_rdata[SB_RXF]  <= rx_full;
          bus_rdata[SB_BUSY] <= busy_bit;
        end
        A_RXDATA: bus_rdata <= {{PAD_W{1'b0}}, rx_buf};
        default:  bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

  p_load_empty_r3: assert property (@(posedge clk) disable iff (rst)
    (tx_take && !wr_tx) |=> tx_empty);

  p_write_full_r3: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> !tx_empty);

  p_rx_set_r7: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_full);

  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_full && !rd_rx) |=> ovr);

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovr |=> ovr);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[REG_DW-1:CHAR_W] == '0);

  p_ss_tracks_busy_r4: assert property (@(posedge clk) disable iff (rst)
    is_master |-> (ss_n_out == !busy_bit));
endmodule

// File: tb/spi_dbuf_ctrl_test.sv
module spi_dbuf_ctrl_test;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        is_master = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sck_out, ss_n_out, sdo;
  logic        sck_in = 1'b0, sel_n_in = 1'b1, slv_mosi = 1'b0, inv = 1'b0;
  logic        sdi;

  int tests = 0, fails = 0;
  int rise_cnt = 0, hi_cnt = 0;
  logic [15:0] mosi_cap = '0;
  logic [15:0] rd;

  always #5 clk = ~clk;

  assign sdi = is_master ? (sdo ^ inv) : slv_mosi;

  spi_dbuf_ctrl #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst(rst), .is_master(is_master), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_out(sck_out), .ss_n_out(ss_n_out), .sdo(sdo),
    .sck_in(sck_in), .sel_n_in(sel_n_in), .sdi(sdi)
  );

  always @(posedge sck_out) begin
    rise_cnt <= rise_cnt + 1;
    mosi_cap <= {mosi_cap[14:0], sdo};
  end
  always @(posedge clk) if (sck_out) hi_cnt <= hi_cnt + 1;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 1000; i++) begin
      reg_rd(3'h0, s);
      if (!s[2]) return;
    end
  endtask

  task automatic clr_mon();
    rise_cnt = 0; hi_cnt = 0; mosi_cap = '0;
  endtask

  task automatic ext_bits(input logic [7:0] b, input int n, output logic [7:0] cap);
    cap = '0;
    for (int i = 7; i > 7 - n; i--) begin
      slv_mosi = b[i];
      repeat (8) @(negedge clk);
      cap = {cap[6:0], sdo};
      sck_in = 1'b1;
      repeat (8) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    reg_rd(3'h0, rd); check("R1 status after reset", rd, 16'h0001);
    reg_rd(3'h4, rd); check("R1 rx after reset", rd, 16'h0000);
    reg_rd(3'h2, rd); check("R2 tx address reads zero", rd, 16'h0000);
  endtask

  task automatic t_master_basic();
    clr_mon(); inv = 1'b0;
    reg_wr(3'h2, 16'hFFA5);
    reg_rd(3'h0, rd); check("R3 empty cleared by write", rd, 16'h0000);
    reg_rd(3'h0, rd); check("R3/R4 loaded, busy set", rd, 16'h0005);
    check("R4 ss_n low while busy", {15'd0, ss_n_out}, 16'h0000);
    wait_idle();
    check("R4 eight clock pulses", 16'(rise_cnt), 16'd8);
    check("R6 half period length", 16'(hi_cnt), 16'(8 * HALF));
    check("R5 MSB-first on sdo", mosi_cap, 16'h00A5);
    check("R4 sck idle low, ss_n high", {14'd0, sck_out, ss_n_out}, 16'h0001);
    reg_rd(3'h0, rd); check("R7 full after byte", rd, 16'h0003);
    reg_rd(3'h4, rd); check("R7/R2 loopback byte", rd, 16'h00A5);
    reg_rd(3'h0, rd); check("R7 full cleared by read", rd, 16'h0001);
  endtask

  task automatic t_master_inv();
    clr_mon(); inv = 1'b1;
    reg_wr(3'h2, 16'h003C);
    @(negedge clk);
    wait_idle();
    reg_rd(3'h4, rd); check("R5 sampled sdi pattern", rd, 16'h00C3);
    inv = 1'b0;
  endtask

  task automatic t_back_to_back();
    clr_mon();
    reg_wr(3'h2, 16'h0011);
    reg_rd(3'h0, rd);
    reg_wr(3'h2, 16'h0022);
    reg_rd(3'h0, rd); check("R9 second byte held", rd, 16'h0004);
    wait (rise_cnt == 16);
    @(negedge clk);
    wait_idle();
    check("R9 both bytes sent in order", mosi_cap, 16'h1122);
    reg_rd(3'h0, rd); check("R8 full after overrun", rd, 16'h0003);
    reg_rd(3'h4, rd); check("R8 newest byte kept", rd, 16'h0022);
  endtask

  task automatic t_slave_xfer();
    logic [7:0] cap;
    is_master = 1'b0;
    repeat (4) @(negedge clk);
    reg_rd(3'h0, rd); check("R10 busy low while deselected", rd, 16'h0001);
    reg_wr(3'h2, 16'h0096);
    sel_n_in = 1'b0;
    repeat (8) @(negedge clk);
    reg_rd(3'h0, rd); check("R10/R3 selected and loaded", rd, 16'h0005);
    ext_bits(8'h5A, 8, cap);
    check("R11 slave sdo MSB first", {8'd0, cap}, 16'h0096);
    reg_rd(3'h0, rd); check("R11 full while selected", rd, 16'h0007);
    reg_rd(3'h4, rd); check("R11 slave received byte", rd, 16'h005A);
    sel_n_in = 1'b1;
    repeat (6) @(negedge clk);
    reg_rd(3'h0, rd); check("R10 busy drops on deselect", rd, 16'h0001);
  endtask

  task automatic t_slave_abort();
    logic [7:0] cap;
    sel_n_in = 1'b0;
    repeat (8) @(negedge clk);
    ext_bits(8'hFF, 3, cap);
    sel_n_in = 1'b1;
    repeat (8) @(negedge clk);
    reg_rd(3'h0, rd); check("R12 partial byte discarded", rd, 16'h0001);
    sel_n_in = 1'b0;
    repeat (8) @(negedge clk);
    ext_bits(8'hC1, 8, cap);
    reg_rd(3'h4, rd); check("R12 realigned after abort", rd, 16'h00C1);
    sel_n_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_master_basic();
    t_master_inv();
    t_back_to_back();
    t_slave_xfer();
    t_slave_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule